// File: doc/BRIEF.md
# Per-Channel Packet Buffer Manager

This block owns a shared on-chip packet store built from sixteen dual-port banks. It divides the store at run time into sixteen circular regions: a transmit region and a receive region for each of eight channels. The host programs one size per region in allocation units. From these sizes the block derives each region's base address, so the regions sit back to back with no gaps.

A host on a 16-bit data path cannot address the store directly. It pushes transmit data through a channel's transmit FIFO port and pops received data through the channel's receive FIFO port. A network-side port does the opposite: it fills receive regions and drains transmit regions. For each region the block keeps a write offset, a read offset and an occupancy count. It reports transmit free space and receive stored bytes for every channel, and it flags host accesses that cannot be honoured.

The unit size is a parameter. `UNIT_WORDS` = 512 gives the full 1 KB unit and a 128 KB store. The default of 4 words (an 8-byte unit) keeps the elaborated memory small while leaving every rule unchanged.

Top module: `pbm_buffer_mgr`

## Requirements
- R1: After reset, every region is 8 units long. Every channel then reports 8×2×`UNIT_WORDS` bytes of transmit free space and 0 receive stored bytes. `cfg_err`, `tx_err` and `rx_err` are all low.
- R2: A `cfg_load` pulse is accepted when all three of these hold: every field of `cfg_sizes` is at most 64 units; the 16 fields sum to 128 units; and the sum of the transmit fields is a multiple of 8 units. Field r is `cfg_sizes[r*7 +: 7]`. Fields 0..7 are the transmit regions of channels 0..7 and fields 8..15 are the receive regions of channels 0..7. An accepted load installs the new sizes, empties every region, and clears `cfg_err`, `tx_err` and `rx_err` on the same edge.
- R3: A `cfg_load` that breaks any rule of R2 sets `cfg_err`. The sizes in force, the stored data and all pointers stay as they were.
- R4: Regions are packed in region-index order. Base addresses are prefix sums of the sizes. Traffic in one region never changes the data held in another, even when neighbouring regions are full.
- R5: A host write (`host_req`=1, `host_we`=1) to channel c appends `host_wdata` to c's transmit region. A network read (`net_req`=1, `net_we`=0) of c returns the words in write order. Each read returns on `net_rdata` with `net_rvalid` high in the cycle after the request.
- R6: A network write (`net_req`=1, `net_we`=1) appends to the receive region of `net_ch`. A host read (`host_req`=1, `host_we`=0) returns the words in arrival order. Each read returns on `host_rdata` with `host_rvalid` high in the cycle after the request.
- R7: The write and read offsets wrap at the region size. Data written after a wrap comes out in order behind the older data.
- R8: `tx_free_bytes` field c equals the transmit region size in bytes minus twice its stored words. `rx_used_bytes` field c equals twice the receive region's stored words. Field c is bits [c*10 +: 10]. Both fields change on the same edge that accepts the access.
- R9: A host write to a full transmit region is dropped and sets `tx_err[c]`. A host read of an empty receive region is dropped, gives no `host_rvalid`, and sets `rx_err[c]`. Both flags stay set until the next accepted configuration.
- R10: A region of size 0 always reports 0 free bytes and 0 stored bytes and rejects every access from either side.
- R11: A host write and a network read of the same transmit region may happen in the same cycle. The read returns the older word, the written word is kept, and the free space is unchanged.
- R12: A network read of an empty transmit region gives no `net_rvalid`. A network write to a full receive region is dropped and the stored count stays at the region size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Request to install `cfg_sizes` |
| cfg_sizes | input | 112 | Sixteen 7-bit region sizes in units |
| cfg_err | output | 1 | Last configuration request was rejected |
| host_req | input | 1 | Host FIFO access strobe |
| host_we | input | 1 | 1 = push to transmit FIFO, 0 = pop from receive FIFO |
| host_ch | input | 3 | Host channel |
| host_wdata | input | 16 | Host write word |
| host_rvalid | output | 1 | Host read word valid |
| host_rdata | output | 16 | Host read word |
| net_req | input | 1 | Network access strobe |
| net_we | input | 1 | 1 = fill receive region, 0 = drain transmit region |
| net_ch | input | 3 | Network channel |
| net_wdata | input | 16 | Network write word |
| net_rvalid | output | 1 | Network read word valid |
| net_rdata | output | 16 | Network read word |
| tx_free_bytes | output | 80 | Per-channel transmit free bytes, 10 bits each |
| rx_used_bytes | output | 80 | Per-channel receive stored bytes, 10 bits each |
| tx_err | output | 8 | Sticky host transmit overflow per channel |
| rx_err | output | 8 | Sticky host receive underflow per channel |

## Verification
The assertions check on every cycle that:
- the installed sizes always total the full store and change only on a load;
- no region's occupancy exceeds its size or leaves zero in a zero-size region;
- offsets stay inside the region and counts step by exactly one;
- the error flags hold until an accepted load;
- a drain of an empty transmit region produces no read strobe.

Data order across wraps, isolation between packed neighbours, old-data return on a simultaneous push and pop, and the accept/reject decision over varied size maps can only be shown by the bench's scenarios. The bench compares the words and byte counts it sees at the ports against values it computes itself.

// File: rtl/pbm_pkg.sv
package pbm_pkg;
    localparam int DATA_W          = 16;
    localparam int CH_DEFAULT      = 8;
    localparam int BANKS_DEFAULT   = 16;
    localparam int BANK_UNITS_DEF  = 8;
    localparam int UNIT_WORDS_DEF  = 4;
    localparam int MAX_UNITS_DEF   = 64;

    typedef enum logic {
        SIDE_TX = 1'b0,
        SIDE_RX = 1'b1
    } side_e;

    typedef struct packed {
        logic push_ok;
        logic pop_ok;
    } grant_t;

    function automatic int ceil_log2(input int v);
        int r;
        r = 0;
        while ((1 << r) < v) r++;
        return (r == 0) ? 1 : r;
    endfunction
endpackage

// File: rtl/pbm_bank.sv
module pbm_bank #(
    parameter int WORDS = 32,
    parameter int AW    = 5,
    parameter int DW    = 16
) (
    input  logic          clk,
    input  logic          a_en,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wd,
    output logic [DW-1:0] a_rd,
    input  logic          b_en,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wd,
    output logic [DW-1:0] b_rd
);
    logic [DW-1:0] mem [WORDS];

    // Reads see the array before this edge's writes: old data on a collision.
    always_ff @(posedge clk) begin
        if (a_en && a_we) mem[a_addr] <= a_wd;
        if (b_en && b_we) mem[b_addr] <= b_wd;
        if (a_en && !a_we) a_rd <= mem[a_addr];
        if (b_en && !b_we) b_rd <= mem[b_addr];
    end
endmodule

// File: rtl/pbm_region_map.sv
module pbm_region_map #(
    parameter int NREG        = 16,
    parameter int NTX         = 8,
    parameter int SZW         = 7,
    parameter int UW          = 8,
    parameter int MAX_UNITS   = 64,
    parameter int TOTAL_UNITS = 128,
    parameter int ALIGN_UNITS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_load,
    input  logic [NREG*SZW-1:0] cfg_sizes,
    output logic                cfg_commit,
    output logic                cfg_err,
    output logic [NREG*SZW-1:0] size_q,
    output logic [NREG*UW-1:0]  base_units
);
    localparam int SUMW      = SZW + $clog2(NREG) + 1;
    localparam int DEF_UNITS = TOTAL_UNITS / NREG;

    logic [SUMW-1:0] new_total, new_tx_total, held_total;
    logic            all_fit, map_ok;

    always_comb begin
        new_total    = '0;
        new_tx_total = '0;
        all_fit      = 1'b1;
        for (int r = 0; r < NREG; r++) begin
            new_total = new_total + SUMW'(cfg_sizes[r*SZW +: SZW]);
            if (r < NTX) new_tx_total = new_tx_total + SUMW'(cfg_sizes[r*SZW +: SZW]);
            if (cfg_sizes[r*SZW +: SZW] > SZW'(MAX_UNITS)) all_fit = 1'b0;
        end
        map_ok = all_fit && (new_total == SUMW'(TOTAL_UNITS))
                 && ((new_tx_total % SUMW'(ALIGN_UNITS)) == '0);
    end

    assign cfg_commit = cfg_load && map_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < NREG; r++) size_q[r*SZW +: SZW] <= SZW'(DEF_UNITS);
            cfg_err <= 1'b0;
        end else if (cfg_load) begin
            if (map_ok) begin
                size_q  <= cfg_sizes;
                cfg_err <= 1'b0;
            end else begin
                cfg_err <= 1'b1;
            end
        end
    end

    always_comb begin
        held_total = '0;
        for (int r = 0; r < NREG; r++) begin
            base_units[r*UW +: UW] = UW'(held_total);
            held_total = held_total + SUMW'(size_q[r*SZW +: SZW]);
        end
    end

    AST_MAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cfg_load |=> $stable(size_q)) else $error("map changed without load"); // R3
    AST_MAP_TOTAL: assert property (@(posedge clk) disable iff (rst)
        held_total == SUMW'(TOTAL_UNITS)) else $error("installed map not full"); // R2
    AST_MAP_REJECT: assert property (@(posedge clk) disable iff (rst)
        (cfg_load && !cfg_commit) |=> cfg_err) else $error("bad map not flagged"); // R3
endmodule

// File: rtl/pbm_region.sv
module pbm_region #(
    parameter int SZW        = 7,
    parameter int UNIT_WORDS = 4,
    parameter int CW         = 9
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clear,
    input  logic [SZW-1:0] size_units,
    input  logic           push,
    input  logic           pop,
    output pbm_pkg::grant_t grant,
    output logic [CW-1:0]  wr_off,
    output logic [CW-1:0]  rd_off,
    output logic [CW-1:0]  occ,
    output logic [CW-1:0]  size_words
);
    assign size_words    = CW'(size_units) * CW'(UNIT_WORDS);
    assign grant.push_ok = push && (occ < size_words);
    assign grant.pop_ok  = pop && (occ != '0);

    function automatic logic [CW-1:0] step(input logic [CW-1:0] p, input logic [CW-1:0] lim);
        return (p + CW'(1) == lim) ? '0 : p + CW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            wr_off <= '0;
            rd_off <= '0;
            occ    <= '0;
        end else begin
            if (grant.push_ok) wr_off <= step(wr_off, size_words);
            if (grant.pop_ok)  rd_off <= step(rd_off, size_words);
            occ <= occ + CW'(grant.push_ok) - CW'(grant.pop_ok);
        end
    end

    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (rst)
        occ <= size_words) else $error("occupancy above size"); // R8
    AST_ZERO_REGION: assert property (@(posedge clk) disable iff (rst)
        (size_words == '0) |-> (occ == '0 && !grant.push_ok && !grant.pop_ok))
        else $error("zero region active"); // R10
    AST_PTR_RANGE: assert property (@(posedge clk) disable iff (rst)
        (size_words != '0) |-> (wr_off < size_words && rd_off < size_words))
        else $error("offset outside region"); // R7
    AST_OCC_STEP: assert property (@(posedge clk) disable iff (rst)
        (grant.push_ok && !grant.pop_ok && !clear) |=> occ == $past(occ) + CW'(1))
        else $error("count did not step"); // R8
endmodule

// File: rtl/pbm_buffer_mgr.sv
module pbm_buffer_mgr #(
    parameter int NCH        = pbm_pkg::CH_DEFAULT,
    parameter int NBANK      = pbm_pkg::BANKS_DEFAULT,
    parameter int BANK_UNITS = pbm_pkg::BANK_UNITS_DEF,
    parameter int UNIT_WORDS = pbm_pkg::UNIT_WORDS_DEF,
    parameter int MAX_UNITS  = pbm_pkg::MAX_UNITS_DEF,
    localparam int DW        = pbm_pkg::DATA_W,
    localparam int NREG      = 2 * NCH,
    localparam int CHW       = $clog2(NCH),
    localparam int SZW       = $clog2(MAX_UNITS + 1),
    localparam int CW        = $clog2(MAX_UNITS * UNIT_WORDS + 1),
    localparam int BCW       = CW + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_load,
    input  logic [NREG*SZW-1:0] cfg_sizes,
    output logic                cfg_err,
    input  logic                host_req,
    input  logic                host_we,
    input  logic [CHW-1:0]      host_ch,
    input  logic [DW-1:0]       host_wdata,
    output logic                host_rvalid,
    output logic [DW-1:0]       host_rdata,
    input  logic                net_req,
    input  logic                net_we,
    input  logic [CHW-1:0]      net_ch,
    input  logic [DW-1:0]       net_wdata,
    output logic                net_rvalid,
    output logic [DW-1:0]       net_rdata,
    output logic [NCH*BCW-1:0]  tx_free_bytes,
    output logic [NCH*BCW-1:0]  rx_used_bytes,
    output logic [NCH-1:0]      tx_err,
    output logic [NCH-1:0]      rx_err
);
    import pbm_pkg::*;

    localparam int TOTAL_UNITS = NBANK * BANK_UNITS;
    localparam int BANK_WORDS  = BANK_UNITS * UNIT_WORDS;
    localparam int AW          = $clog2(TOTAL_UNITS * UNIT_WORDS);
    localparam int BAW         = $clog2(BANK_WORDS);
    localparam int BSW         = ceil_log2(NBANK);
    localparam int UW          = $clog2(TOTAL_UNITS + 1);
    localparam int RW          = $clog2(NREG);

    logic                cfg_commit;
    logic [NREG*SZW-1:0] size_q;
    logic [NREG*UW-1:0]  base_units;

    pbm_region_map #(
        .NREG(NREG), .NTX(NCH), .SZW(SZW), .UW(UW), .MAX_UNITS(MAX_UNITS),
        .TOTAL_UNITS(TOTAL_UNITS), .ALIGN_UNITS(BANK_UNITS)
    ) u_map (
        .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_sizes(cfg_sizes),
        .cfg_commit(cfg_commit), .cfg_err(cfg_err), .size_q(size_q), .base_units(base_units)
    );

    // Region r < NCH is the transmit region of channel r; the rest are receive regions.
    logic [NREG-1:0] push_req, pop_req;
    grant_t          grant  [NREG];
    logic [CW-1:0]   wr_off [NREG];
    logic [CW-1:0]   rd_off [NREG];
    logic [CW-1:0]   occ    [NREG];
    logic [CW-1:0]   size_w [NREG];
    logic [AW-1:0]   base_w [NREG];

    for (genvar r = 0; r < NREG; r++) begin : g_region
        if (r < NCH) begin : g_tx
            assign push_req[r] = host_req && host_we && (host_ch == CHW'(r));
            assign pop_req[r]  = net_req && !net_we && (net_ch == CHW'(r));
        end else begin : g_rx
            assign push_req[r] = net_req && net_we && (net_ch == CHW'(r - NCH));
            assign pop_req[r]  = host_req && !host_we && (host_ch == CHW'(r - NCH));
        end
        assign base_w[r] = AW'(32'(base_units[r*UW +: UW]) * UNIT_WORDS);

        pbm_region #(.SZW(SZW), .UNIT_WORDS(UNIT_WORDS), .CW(CW)) u_reg (
            .clk(clk), .rst(rst), .clear(cfg_commit), .size_units(size_q[r*SZW +: SZW]),
            .push(push_req[r]), .pop(pop_req[r]), .grant(grant[r]),
            .wr_off(wr_off[r]), .rd_off(rd_off[r]), .occ(occ[r]), .size_words(size_w[r])
        );
    end

    // Host side: push to transmit, pop from receive.
    side_e          h_side;
    logic [RW-1:0]  h_reg, n_reg;
    logic           h_ok, n_ok;
    logic [AW-1:0]  h_addr, n_addr;
    logic [BSW-1:0] h_bank, n_bank, h_bank_q, n_bank_q;

    assign h_side = host_we ? SIDE_TX : SIDE_RX;
    assign h_reg  = RW'(host_ch) + ((h_side == SIDE_TX) ? RW'(0) : RW'(NCH));
    assign n_reg  = RW'(net_ch) + (net_we ? RW'(NCH) : RW'(0));
    assign h_ok   = host_req && (host_we ? grant[h_reg].push_ok : grant[h_reg].pop_ok);
    assign n_ok   = net_req && (net_we ? grant[n_reg].push_ok : grant[n_reg].pop_ok);
    assign h_addr = base_w[h_reg] + AW'(host_we ? wr_off[h_reg] : rd_off[h_reg]);
    assign n_addr = base_w[n_reg] + AW'(net_we ? wr_off[n_reg] : rd_off[n_reg]);
    assign h_bank = BSW'(h_addr >> BAW);
    assign n_bank = BSW'(n_addr >> BAW);

    logic [DW-1:0] a_rd [NBANK];
    logic [DW-1:0] b_rd [NBANK];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        pbm_bank #(.WORDS(BANK_WORDS), .AW(BAW), .DW(DW)) u_bank (
            .clk(clk),
            .a_en(h_ok && h_bank == BSW'(b)), .a_we(host_we),
            .a_addr(h_addr[BAW-1:0]), .a_wd(host_wdata), .a_rd(a_rd[b]),
            .b_en(n_ok && n_bank == BSW'(b)), .b_we(net_we),
            .b_addr(n_addr[BAW-1:0]), .b_wd(net_wdata), .b_rd(b_rd[b])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            host_rvalid <= 1'b0;
            net_rvalid  <= 1'b0;
            h_bank_q    <= '0;
            n_bank_q    <= '0;
        end else begin
            host_rvalid <= h_ok && !host_we;
            net_rvalid  <= n_ok && !net_we;
            h_bank_q    <= h_bank;
            n_bank_q    <= n_bank;
        end
    end

    assign host_rdata = a_rd[h_bank_q];
    assign net_rdata  = b_rd[n_bank_q];

    always_ff @(posedge clk) begin
        if (rst || cfg_commit) begin
            tx_err <= '0;
            rx_err <= '0;
        end else if (host_req && !h_ok) begin
            if (host_we) tx_err[host_ch] <= 1'b1;
            else         rx_err[host_ch] <= 1'b1;
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_count
        assign tx_free_bytes[c*BCW +: BCW] = {size_w[c] - occ[c], 1'b0};
        assign rx_used_bytes[c*BCW +: BCW] = {occ[NCH + c], 1'b0};
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        !cfg_commit |=> ((tx_err & $past(tx_err)) == $past(tx_err)) &&
                        ((rx_err & $past(rx_err)) == $past(rx_err)))
        else $error("error flag dropped"); // R9
    AST_NET_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (net_req && !net_we && occ[n_reg] == '0) |=> !net_rvalid)
        else $error("read strobe from empty region"); // R12
    AST_HOST_RD_LAT: assert property (@(posedge clk) disable iff (rst)
        (host_req && !host_we && occ[h_reg] != '0 && !cfg_commit) |=> host_rvalid)
        else $error("host read lost"); // R6
endmodule

// File: tb/pbm_buffer_mgr_test.sv
module pbm_buffer_mgr_test;
    localparam int NCH = 8, SZW = 7, BCW = 10, UB = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_load = 1'b0;
    logic [16*SZW-1:0] cfg_sizes = '0;
    logic cfg_err;
    logic host_req = 1'b0, host_we = 1'b0;
    logic [2:0] host_ch = '0;
    logic [15:0] host_wdata = '0;
    logic host_rvalid;
    logic [15:0] host_rdata;
    logic net_req = 1'b0, net_we = 1'b0;
    logic [2:0] net_ch = '0;
    logic [15:0] net_wdata = '0;
    logic net_rvalid;
    logic [15:0] net_rdata;
    logic [NCH*BCW-1:0] tx_free_bytes, rx_used_bytes;
    logic [NCH-1:0] tx_err, rx_err;

    int total = 0, bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pbm_buffer_mgr uut (.*);

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int txf(input int c); return int'(tx_free_bytes[c*BCW +: BCW]); endfunction
    function automatic int rxu(input int c); return int'(rx_used_bytes[c*BCW +: BCW]); endfunction

    function automatic logic [16*SZW-1:0] mk(input int t06, input int t7, input int r06, input int r7);
        logic [16*SZW-1:0] v;
        for (int r = 0; r < 16; r++)
            v[r*SZW +: SZW] = SZW'((r < 7) ? t06 : (r == 7) ? t7 : (r < 15) ? r06 : r7);
        return v;
    endfunction

    task automatic load(input logic [16*SZW-1:0] s);
        @(negedge clk); cfg_sizes = s; cfg_load = 1'b1;
        @(negedge clk); cfg_load = 1'b0;
    endtask

    task automatic hwr(input int ch, input int d);
        @(negedge clk); host_req = 1'b1; host_we = 1'b1; host_ch = 3'(ch); host_wdata = 16'(d);
        @(negedge clk); host_req = 1'b0;
    endtask

    task automatic hrd(input int ch, output int v, output int d);
        @(negedge clk); host_req = 1'b1; host_we = 1'b0; host_ch = 3'(ch);
        @(negedge clk); host_req = 1'b0; v = int'(host_rvalid); d = int'(host_rdata);
    endtask

    task automatic nwr(input int ch, input int d);
        @(negedge clk); net_req = 1'b1; net_we = 1'b1; net_ch = 3'(ch); net_wdata = 16'(d);
        @(negedge clk); net_req = 1'b0;
    endtask

    task automatic nrd(input int ch, output int v, output int d);
        @(negedge clk); net_req = 1'b1; net_we = 1'b0; net_ch = 3'(ch);
        @(negedge clk); net_req = 1'b0; v = int'(net_rvalid); d = int'(net_rdata);
    endtask

    // Configuration vectors: {tx ch0-6, tx ch7, rx ch0-6, rx ch7, expect accept}.
    localparam logic [28:0] CFGV [7] = '{
        {7'd8,  7'd8,  7'd8, 7'd8,  1'b1},
        {7'd16, 7'd0,  7'd0, 7'd16, 1'b1},
        {7'd8,  7'd8,  7'd8, 7'd0,  1'b0},
        {7'd0,  7'd64, 7'd0, 7'd64, 1'b1},
        {7'd9,  7'd2,  7'd8, 7'd7,  1'b0},
        {7'd0,  7'd72, 7'd8, 7'd0,  1'b0},
        {7'd8,  7'd8,  7'd8, 7'd8,  1'b1}
    };

    initial begin
        int v, d, prev7;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 tx free ch0", txf(0), 8 * UB);
        chk("R1 tx free ch7", txf(7), 8 * UB);
        chk("R1 rx used ch3", rxu(3), 0);
        chk("R1 flags", int'({cfg_err, tx_err, rx_err}), 0);

        prev7 = txf(7);
        for (int i = 0; i < 7; i++) begin
            load(mk(int'(CFGV[i][28:22]), int'(CFGV[i][21:15]), int'(CFGV[i][14:8]), int'(CFGV[i][7:1])));
            if (CFGV[i][0]) begin
                chk("R2 accepted", int'(cfg_err), 0);
                chk("R2 tx free ch0", txf(0), int'(CFGV[i][28:22]) * UB);
                chk("R2 tx free ch7", txf(7), int'(CFGV[i][21:15]) * UB);
                chk("R2 rx used ch7", rxu(7), 0);
            end else begin
                chk("R3 rejected", int'(cfg_err), 1);
                chk("R3 map kept", txf(7), prev7);
            end
            prev7 = txf(7);
        end

        // R8 / R5: counts and order through the transmit path
        for (int i = 0; i < 3; i++) hwr(2, 16'h3000 + i);
        chk("R8 tx free after 3 pushes", txf(2), 64 - 6);
        for (int i = 0; i < 3; i++) begin
            nrd(2, v, d);
            chk("R5 net rvalid", v, 1);
            chk("R5 net data order", d, 16'h3000 + i);
        end
        chk("R8 tx free drained", txf(2), 64);

        // R6: receive path
        nwr(5, 16'h5A01); nwr(5, 16'h5A02);
        chk("R8 rx used", rxu(5), 4);
        hrd(5, v, d);
        chk("R6 host rvalid", v, 1);
        chk("R6 host data", d, 16'h5A01);
        chk("R8 rx used after pop", rxu(5), 2);

        // R9 / R4 / R7: full neighbours, overflow, wrap
        for (int i = 0; i < 32; i++) hwr(0, 16'h1000 + i);
        for (int i = 0; i < 32; i++) hwr(1, 16'h2000 + i);
        chk("R9 full free", txf(0), 0);
        hwr(0, 16'hDEAD);
        chk("R9 overflow free", txf(0), 0);
        chk("R9 tx_err set", int'(tx_err[0]), 1);
        for (int i = 0; i < 32; i++) begin
            nrd(0, v, d);
            chk("R4 ch0 data intact", d, 16'h1000 + i);
        end
        chk("R9 tx_err sticky", int'(tx_err[0]), 1);
        for (int i = 0; i < 10; i++) begin
            nrd(1, v, d);
            chk("R4 ch1 data intact", d, 16'h2000 + i);
        end
        for (int i = 0; i < 10; i++) hwr(1, 16'h2100 + i);
        chk("R7 full after wrap", txf(1), 0);
        for (int i = 0; i < 32; i++) begin
            nrd(1, v, d);
            chk("R7 order across wrap", d, (i < 22) ? 16'h200A + i : 16'h2100 + i - 22);
        end

        hrd(3, v, d);
        chk("R9 empty read no rvalid", v, 0);
        chk("R9 rx_err set", int'(rx_err[3]), 1);

        // R11: simultaneous push and pop on one transmit region
        hwr(4, 16'h4444);
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b1; host_ch = 3'd4; host_wdata = 16'h5555;
        net_req = 1'b1; net_we = 1'b0; net_ch = 3'd4;
        @(negedge clk);
        host_req = 1'b0; net_req = 1'b0;
        chk("R11 old word returned", int'(net_rdata), 16'h4444);
        chk("R11 free unchanged", txf(4), 62);
        nrd(4, v, d);
        chk("R11 new word kept", d, 16'h5555);

        // R12: network-side rejects
        nrd(6, v, d);
        chk("R12 empty drain no rvalid", v, 0);
        for (int i = 0; i < 33; i++) nwr(6, 16'h6000 + i);
        chk("R12 rx full count", rxu(6), 64);
        hrd(6, v, d);
        chk("R12 oldest word kept", d, 16'h6000);

        // R3: rejected map keeps data
        hwr(3, 16'h7001); hwr(3, 16'h7002);
        load(mk(8, 8, 8, 0));
        chk("R3 free kept", txf(3), 60);
        nrd(3, v, d); nrd(3, v, d);
        chk("R3 data kept", d, 16'h7002);

        // R10 / R2: zero-size regions and clearing on accept
        load(mk(16, 0, 0, 16));
        chk("R2 tx_err cleared", int'(tx_err[0]), 0);
        chk("R2 rx region emptied", rxu(6), 0);
        chk("R10 zero tx free", txf(7), 0);
        hwr(7, 16'h0BAD);
        chk("R10 zero tx free after write", txf(7), 0);
        chk("R10 zero tx rejects", int'(tx_err[7]), 1);
        nwr(0, 16'h0BAD);
        chk("R10 zero rx used", rxu(0), 0);
        hrd(0, v, d);
        chk("R10 zero rx read rejected", v, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule